// File: doc/BRIEF.md
# Host Register Access Controller

This block connects a byte-wide, strobe-qualified CPU port to the register file of a character-display core. Two select lines and a read/write line pick one of three registers: the instruction register, the data register or the expansion register. The block also holds the 7-bit address counter and the busy flag that the host polls. A fourth select code selects nothing.

Setting an address through the instruction or expansion register loads the counter. The block then fetches the addressed word from a synchronous RAM into the data register, so the first data read returns it directly. Each data-register read or write steps the counter up or down, as a mode pin chooses, and refreshes the data register from the new address. While that RAM traffic completes, the busy flag is raised and further accesses are dropped.

The host drives the select, read/write and write-data lines and then pulses the enable strobe. The block acts when the strobe falls, after the strobe has been synchronised into the core clock. Read data is presented combinationally for as long as the select lines stay stable.

Top module: `host_reg_ctrl`

## Requirements
- R1: The select code {cpu_sel1,cpu_sel0} picks the register: 2'b11 data register, 2'b10 instruction register, 2'b00 expansion register. Code 2'b01 selects nothing: a write there changes no state, and a read there returns 8'h00.
- R2: A read on the instruction-register code returns the busy flag on bit 7 and the address counter on bits 6..0. After reset this read gives 8'h00.
- R3: A write on the expansion code with bit 7 clear stores bits 6..0 as the contrast code. A read on the expansion code returns {1'b0, contrast}. The contrast code is 0 after reset.
- R4: A write on the instruction or expansion code with bit 7 set loads bits 6..0 into the address counter and fetches RAM at that address into the data register. An instruction-register write with bit 7 clear changes nothing.
- R5: A data-register write stores the byte to RAM at the current counter value. The counter then steps, and the data register is refetched from the new address.
- R6: A data-register read returns the data register on cpu_rdata. When the strobe ends, the counter steps and the data register is refetched from the new address.
- R7: The counter steps by +1 when step_down is 0 and by -1 when step_down is 1, wrapping modulo 128 (7'h7F+1 = 7'h00, 7'h00-1 = 7'h7F).
- R8: Every accepted access that reaches RAM raises the busy flag from the next cycle for BUSY_CYCLES cycles. The refetch into the data register completes inside that window.
- R9: While busy, any strobed access is ignored: writes change no register or counter, and a data read does not step. Status reads still work.
- R10: An access acts only when the synchronised strobe falls. While the strobe is held high, the data read value stays constant and nothing steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_en | input | 1 | Host enable strobe; the access acts on its falling edge |
| cpu_sel0 | input | 1 | Register select, low bit |
| cpu_sel1 | input | 1 | Register select, high bit |
| cpu_rd | input | 1 | 1 = read, 0 = write |
| cpu_wdata | input | DATA_W | Host write data |
| cpu_rdata | output | DATA_W | Host read data, combinational from select and state |
| step_down | input | 1 | Counter step direction: 0 increment, 1 decrement |
| ram_addr | output | DATA_W-1 | RAM address (the address counter) |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | DATA_W | RAM write data |
| ram_re | output | 1 | RAM read enable; data returns one cycle later |
| ram_rdata | input | DATA_W | RAM read data |

## Verification
The embedded assertions check on every cycle that:
- a RAM write is always followed by a refetch read, and the two never coincide;
- the busy flag rises after each accepted RAM access and covers the data-register load;
- the contrast code stays frozen while busy;
- each strobe fall yields a single action pulse.

Only the bench scenarios can show the rest: which RAM word ends up in the data register, the counter values including wrap in both directions, the select-code map, that dropped accesses leave no trace, and that a long strobe does not step early.

// File: rtl/hrac_pkg.sv
package hrac_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_IR_WR,
    ACC_STAT_RD,
    ACC_DR_WR,
    ACC_DR_RD,
    ACC_ER_WR,
    ACC_ER_RD
  } acc_e;
endpackage

// File: rtl/hrac_strobe_sync.sv
module hrac_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic fall
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q, prev_d;

  always_comb begin
    sh_d   = {sh_q[STAGES-2:0], strobe};
    prev_d = sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= prev_d;
    end
  end

  assign fall = prev_q & ~sh_q[STAGES-1];

  // R10
  single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/hrac_decode.sv
module hrac_decode
  import hrac_pkg::*;
(
  input  logic sel1,
  input  logic sel0,
  input  logic rd,
  output acc_e acc
);
  always_comb begin
    unique case ({sel1, sel0})
      2'b11:   acc = rd ? ACC_DR_RD   : ACC_DR_WR;
      2'b10:   acc = rd ? ACC_STAT_RD : ACC_IR_WR;
      2'b00:   acc = rd ? ACC_ER_RD   : ACC_ER_WR;
      default: acc = ACC_NONE;
    endcase
  end
endmodule

// File: rtl/hrac_addr_ctr.sv
module hrac_addr_ctr #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_val,
  input  logic          step_en,
  input  logic          step_down,
  output logic [AW-1:0] count
);
  logic [AW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_en)
      cnt_d = load_val;
    else if (step_en)
      cnt_d = step_down ? cnt_q - 1'b1 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/host_reg_ctrl.sv
module host_reg_ctrl
  import hrac_pkg::*;
#(
  parameter int  DATA_W      = 8,
  parameter int  BUSY_CYCLES = 4,
  parameter int  SYNC_STAGES = 2,
  localparam int ADDR_W      = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_en,
  input  logic              cpu_sel0,
  input  logic              cpu_sel1,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              step_down,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_re,
  input  logic [DATA_W-1:0] ram_rdata
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] BUSY_LOAD = CNT_W'(BUSY_CYCLES);

  logic              fall, accept, busy, is_set, ram_access, step_en;
  acc_e              acc;
  logic [ADDR_W-1:0] ac;

  logic [ADDR_W-1:0] contrast_q, contrast_d;
  logic [DATA_W-1:0] dr_q, dr_d;
  logic [DATA_W-1:0] wbuf_q, wbuf_d;
  logic              wr_pend_q, wr_pend_d;
  logic              rd_pend_q, rd_pend_d;
  logic              ld_pend_q, ld_pend_d;
  logic [CNT_W-1:0]  busy_q, busy_d;

  hrac_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe(cpu_en), .fall(fall)
  );

  hrac_decode u_dec (
    .sel1(cpu_sel1), .sel0(cpu_sel0), .rd(cpu_rd), .acc(acc)
  );

  assign busy    = (busy_q != '0);
  assign accept  = fall & ~busy;
  assign is_set  = ((acc == ACC_IR_WR) || (acc == ACC_ER_WR)) && cpu_wdata[DATA_W-1];
  assign step_en = (accept && (acc == ACC_DR_RD)) || wr_pend_q;

  hrac_addr_ctr #(.AW(ADDR_W)) u_ac (
    .clk(clk), .rst_n(rst_n),
    .load_en(accept && is_set), .load_val(cpu_wdata[ADDR_W-1:0]),
    .step_en(step_en), .step_down(step_down), .count(ac)
  );

  // next-state logic
  always_comb begin
    contrast_d = contrast_q;
    if (accept && (acc == ACC_ER_WR) && !cpu_wdata[DATA_W-1])
      contrast_d = cpu_wdata[ADDR_W-1:0];

    wr_pend_d = accept && (acc == ACC_DR_WR);
    wbuf_d    = wr_pend_d ? cpu_wdata : wbuf_q;
    rd_pend_d = (accept && (is_set || (acc == ACC_DR_RD))) || wr_pend_q;
    ld_pend_d = rd_pend_q;
    dr_d      = ld_pend_q ? ram_rdata : dr_q;

    ram_access = accept && (is_set || (acc == ACC_DR_WR) || (acc == ACC_DR_RD));
    if (ram_access)   busy_d = BUSY_LOAD;
    else if (busy)    busy_d = busy_q - 1'b1;
    else              busy_d = '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      contrast_q <= '0;
      dr_q       <= '0;
      wbuf_q     <= '0;
      wr_pend_q  <= 1'b0;
      rd_pend_q  <= 1'b0;
      ld_pend_q  <= 1'b0;
      busy_q     <= '0;
    end else begin
      contrast_q <= contrast_d;
      dr_q       <= dr_d;
      wbuf_q     <= wbuf_d;
      wr_pend_q  <= wr_pend_d;
      rd_pend_q  <= rd_pend_d;
      ld_pend_q  <= ld_pend_d;
      busy_q     <= busy_d;
    end
  end

  // RAM port
  assign ram_addr  = ac;
  assign ram_we    = wr_pend_q;
  assign ram_wdata = wbuf_q;
  assign ram_re    = rd_pend_q;

  // host read-back
  always_comb begin
    unique case (acc)
      ACC_DR_RD:   cpu_rdata = dr_q;
      ACC_STAT_RD: cpu_rdata = {busy, ac};
      ACC_ER_RD:   cpu_rdata = {1'b0, contrast_q};
      default:     cpu_rdata = '0;
    endcase
  end

  // R5
  wr_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> ram_re);
  // R5
  we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re));
  // R8
  busy_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_access |=> busy);
  // R8
  load_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pend_q |-> busy);
  // R9
  contrast_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(contrast_q));

  initial begin
    // R8
    busy_window_chk: assert (BUSY_CYCLES >= 3);
  end
endmodule

// File: tb/host_reg_ctrl_test.sv
module host_reg_ctrl_test;
  localparam int BUSY = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_en = 1'b0, cpu_sel0 = 1'b0, cpu_sel1 = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic       step_down = 1'b0;
  logic [6:0] ram_addr;
  logic       ram_we, ram_re;
  logic [7:0] ram_wdata;
  logic [7:0] ram_rdata;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0] ram   [128];
  logic [7:0] model [128];
  logic [7:0] ram_q = 8'h00;

  logic [7:0] exp_q[$];
  logic [7:0] msk_q[$];
  string      tag_q[$];
  event       smp;

  always #5 clk = ~clk;

  host_reg_ctrl #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_en(cpu_en), .cpu_sel0(cpu_sel0),
    .cpu_sel1(cpu_sel1), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .step_down(step_down), .ram_addr(ram_addr),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_re(ram_re),
    .ram_rdata(ram_rdata)
  );

  // environment RAM: synchronous read
  always @(posedge clk) begin
    if (ram_we) ram[ram_addr] <= ram_wdata;
    if (ram_re) ram_q <= ram[ram_addr];
  end
  assign ram_rdata = ram_q;

  // monitor: pops expected items and compares
  always @(smp) begin
    logic [7:0] e, m;
    string t;
    e = exp_q.pop_front();
    m = msk_q.pop_front();
    t = tag_q.pop_front();
    checks++;
    if ((cpu_rdata & m) !== (e & m)) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", t, cpu_rdata & m, e & m);
    end
  end

  function automatic logic [6:0] nxt(logic [6:0] a);
    return step_down ? a - 7'd1 : a + 7'd1;
  endfunction

  task automatic expect_now(logic [7:0] e, logic [7:0] m, string t);
    exp_q.push_back(e);
    msk_q.push_back(m);
    tag_q.push_back(t);
    #2 -> smp;
    #1;
  endtask

  // strobed write
  task automatic wr(logic s1, logic s0, logic [7:0] d);
    @(negedge clk);
    cpu_sel1 = s1; cpu_sel0 = s0; cpu_rd = 1'b0; cpu_wdata = d; cpu_en = 1'b1;
    @(negedge clk);
    cpu_en = 1'b0;
    repeat (BUSY + 6) @(negedge clk);
  endtask

  // strobed read with a check while the strobe is high
  task automatic rd(logic s1, logic s0, logic [7:0] e, string t);
    @(negedge clk);
    cpu_sel1 = s1; cpu_sel0 = s0; cpu_rd = 1'b1; cpu_en = 1'b1;
    expect_now(e, 8'hFF, t);
    @(negedge clk);
    cpu_en = 1'b0;
    repeat (BUSY + 6) @(negedge clk);
  endtask

  logic [6:0] ac;

  initial begin
    for (int i = 0; i < 128; i++) begin
      ram[i]   = 8'((i * 37 + 11) & 8'hFF);
      model[i] = 8'((i * 37 + 11) & 8'hFF);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    rd(1, 0, 8'h00, "R2 status after reset");
    rd(0, 0, 8'h00, "R3 contrast after reset");
    rd(0, 1, 8'h00, "R1 unselected read is zero");

    // address set and sequential reads
    wr(1, 0, 8'h90); ac = 7'h10;
    rd(1, 0, {1'b0, ac}, "R4 counter loaded by address set");
    rd(1, 1, model[ac], "R4 prefetched word"); ac = nxt(ac);
    rd(1, 1, model[ac], "R6 read refetches next word"); ac = nxt(ac);
    rd(1, 0, {1'b0, ac}, "R6 counter stepped by reads");

    // down direction
    step_down = 1'b1;
    rd(1, 1, model[ac], "R7 read before downward step"); ac = nxt(ac);
    rd(1, 1, model[ac], "R7 downward refetch"); ac = nxt(ac);
    rd(1, 0, {1'b0, ac}, "R7 counter after downward reads");

    // wrap upward and downward
    step_down = 1'b0;
    wr(1, 0, 8'hFF); ac = 7'h7F;
    rd(1, 1, model[ac], "R7 word at top address"); ac = nxt(ac);
    rd(1, 0, 8'h00, "R7 upward wrap to zero");
    rd(1, 1, model[0], "R7 word after upward wrap");
    wr(1, 0, 8'h80);
    step_down = 1'b1;
    rd(1, 1, model[0], "R7 word at zero");
    rd(1, 0, 8'h7F, "R7 downward wrap to top");
    step_down = 1'b0;

    // data write
    wr(1, 0, 8'hA0);
    wr(1, 1, 8'hA5); model[7'h20] = 8'hA5;
    rd(1, 0, 8'h21, "R5 counter steps after write");
    rd(1, 1, model[7'h21], "R5 refetch after write");
    wr(1, 0, 8'hA0);
    rd(1, 1, 8'hA5, "R5 written byte stored in RAM");

    // expansion register
    wr(0, 0, 8'h15);
    rd(0, 0, 8'h15, "R3 contrast read back");
    wr(0, 0, 8'h85);
    rd(1, 0, 8'h05, "R4 address set through expansion code");
    rd(1, 1, model[5], "R4 prefetch through expansion code");
    rd(0, 0, 8'h15, "R4 address set keeps contrast");

    // instruction write without address bit
    wr(1, 0, 8'h33);
    rd(1, 0, 8'h06, "R4 non-address instruction ignored");

    // unselected code write
    wr(0, 1, 8'h7E);
    rd(0, 0, 8'h15, "R1 unselected write keeps contrast");
    rd(1, 0, 8'h06, "R1 unselected write keeps counter");

    // busy flag visible right after an access
    @(negedge clk);
    cpu_sel1 = 1; cpu_sel0 = 0; cpu_rd = 0; cpu_wdata = 8'h88; cpu_en = 1;
    @(negedge clk); cpu_en = 0;
    repeat (3) @(negedge clk);
    cpu_rd = 1'b1;
    expect_now(8'h80, 8'h80, "R8 busy flag set during access");
    repeat (BUSY + 6) @(negedge clk);
    rd(1, 0, 8'h08, "R8 busy flag clears");

    // access inside the busy window is dropped
    @(negedge clk);
    cpu_sel1 = 1; cpu_sel0 = 0; cpu_rd = 0; cpu_wdata = 8'h90; cpu_en = 1;
    @(negedge clk); cpu_en = 0;
    repeat (3) @(negedge clk);
    cpu_sel1 = 0; cpu_sel0 = 0; cpu_wdata = 8'h2A; cpu_en = 1;
    @(negedge clk); cpu_en = 0;
    repeat (BUSY + 8) @(negedge clk);
    rd(0, 0, 8'h15, "R9 write during busy ignored");
    rd(1, 0, 8'h10, "R9 counter from accepted access only");

    // long strobe: nothing steps until it falls
    @(negedge clk);
    cpu_sel1 = 1; cpu_sel0 = 1; cpu_rd = 1; cpu_en = 1;
    expect_now(model[7'h10], 8'hFF, "R10 value early in long strobe");
    repeat (6) @(negedge clk);
    expect_now(model[7'h10], 8'hFF, "R10 value late in long strobe");
    @(negedge clk); cpu_en = 0;
    repeat (BUSY + 6) @(negedge clk);
    rd(1, 0, 8'h11, "R10 single step after strobe falls");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule